// File: doc/BRIEF.md
# Quadrature Encoder Counter

This block converts a pair of quadrature phase signals into a position count. Each level change on the phase or phases selected by the mode input moves the counter one step up or down. The direction comes from how the two phases relate at the moment of the change. The counter runs over the range from zero to a programmed reload value. When it wraps at either end of that range it raises a one-cycle update pulse.

The phase inputs must already be synchronised to the clock and filtered. The reload value is read as a plain level and should be set before counting is enabled. Software chooses which phases count: phase A only, phase B only, or both. Mode 0 stops encoder counting.

Top module: `quad_enc_counter`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `count` is 0, `dir` is 0 and `wrap_pulse` is 0. The phase levels present when reset is released do not count as edges.
- R2: With `mode` = 1 (bit 0 selects phase A), only level changes of `ph_a` step the counter. Changes of `ph_b` alone leave `count` unchanged.
- R3: With `mode` = 2 (bit 1 selects phase B), only level changes of `ph_b` step the counter. Changes of `ph_a` alone leave `count` unchanged.
- R4: With `mode` = 3, level changes of either phase step the counter.
- R5: An edge of `ph_a` counts up when the new `ph_a` differs from `ph_b`, and down otherwise. An edge of `ph_b` counts up when the new `ph_b` equals `ph_a`, and down otherwise.
- R6: `dir` is 0 after an up step and 1 after a down step. It holds its value in every cycle without a counted edge.
- R7: An up step from a count of `reload` or above sets `count` to 0 and raises `wrap_pulse`.
- R8: A down step from a count of 0 sets `count` to `reload` and raises `wrap_pulse`.
- R9: `wrap_pulse` is high for exactly the cycle after a wrapping step and is low at all other times.
- R10: With `mode` = 0 or `cnt_en` = 0, phase edges leave `count` and `dir` unchanged.
- R11: If both phases change level in the same cycle, the transition is illegal. `count` and `dir` stay unchanged and no pulse is raised.
- R12: A counted edge sampled at a clock edge shows on `count` at that same edge, one register stage from the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Counting enable |
| mode | input | 2 | Edge-source select: 0 off, 1 phase A, 2 phase B, 3 both |
| reload | input | CNT_W | Top of the counting range |
| ph_a | input | 1 | Phase A, synchronised |
| ph_b | input | 1 | Phase B, synchronised |
| count | output | CNT_W | Current count |
| dir | output | 1 | Last counted direction, 1 = down |
| wrap_pulse | output | 1 | One-cycle pulse on wrap at either end |

## Verification
On every cycle the assertions check the following:
- Both wrap directions land on the correct value and raise the pulse.
- The pulse never appears without a step.
- Count and direction hold when no step occurs.
- An illegal double change never produces a step.

Only the bench scenarios can show the rest, because the assertions do not compare against any independent model of the phases:
- The per-mode edge selection is correct.
- The up/down rule matches the phase relationship.
- The count as a whole follows long random phase walks.

// File: rtl/qenc_pkg.sv
package qenc_pkg;
   typedef enum logic [1:0] {
      QM_OFF  = 2'd0,
      QM_A    = 2'd1,
      QM_B    = 2'd2,
      QM_BOTH = 2'd3
   } qenc_mode_e;

   localparam int unsigned QENC_PHASES = 2;
endpackage

// File: rtl/qenc_edge_detect.sv
module qenc_edge_detect
   import qenc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cnt_en,
   input  logic [1:0] mode,
   input  logic       ph_a,
   input  logic       ph_b,
   output logic       step,
   output logic       step_up
);
   logic [QENC_PHASES-1:0] ph_now;
   logic [QENC_PHASES-1:0] ph_prev;
   logic [QENC_PHASES-1:0] edg;
   logic                   primed;
   logic                   illegal;
   logic                   sel_a;
   logic                   sel_b;

   assign ph_now = {ph_b, ph_a};

   // One history register per phase
   generate
      for (genvar gi = 0; gi < QENC_PHASES; gi++) begin : g_phase
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ph_prev[gi] <= 1'b0;
            else        ph_prev[gi] <= ph_now[gi];
         end
         assign edg[gi] = primed & (ph_now[gi] ^ ph_prev[gi]);
      end
   endgenerate

   // History is not valid until one sample has been taken after reset
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) primed <= 1'b0;
      else        primed <= 1'b1;
   end

   assign illegal = edg[0] & edg[1];
   assign sel_a   = (mode == QM_A) || (mode == QM_BOTH);
   assign sel_b   = (mode == QM_B) || (mode == QM_BOTH);

   always_comb begin
      step = cnt_en & ~illegal & ((edg[0] & sel_a) | (edg[1] & sel_b));
      if (edg[0]) step_up = ph_a ^ ph_b;
      else        step_up = ~(ph_a ^ ph_b);
   end

   // R11: a simultaneous change of both phases never produces a step
   a_r11_illegal_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      ((ph_a != $past(ph_a)) && (ph_b != $past(ph_b))) |-> !step);

   // R10: mode 0 or a low enable never steps
   a_r10_off_no_step: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode == QM_OFF) || !cnt_en) |-> !step);
endmodule

// File: rtl/qenc_wrap_counter.sv
module qenc_wrap_counter #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic             step_up,
   input  logic [CNT_W-1:0] reload,
   output logic [CNT_W-1:0] count,
   output logic             wrap_pulse
);
   localparam logic [CNT_W-1:0] CNT_ZERO = '0;
   localparam logic [CNT_W-1:0] CNT_ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

   logic [CNT_W-1:0] cnt_nxt;
   logic             wrap_nxt;

   always_comb begin
      cnt_nxt  = count;
      wrap_nxt = 1'b0;
      if (step) begin
         if (step_up) begin
            if (count >= reload) begin
               cnt_nxt  = CNT_ZERO;
               wrap_nxt = 1'b1;
            end else begin
               cnt_nxt = count + CNT_ONE;
            end
         end else begin
            if (count == CNT_ZERO) begin
               cnt_nxt  = reload;
               wrap_nxt = 1'b1;
            end else begin
               cnt_nxt = count - CNT_ONE;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count      <= CNT_ZERO;
         wrap_pulse <= 1'b0;
      end else begin
         count      <= cnt_nxt;
         wrap_pulse <= wrap_nxt;
      end
   end

   // R7
   a_r7_up_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (step && step_up && (count >= reload)) |=> (count == CNT_ZERO) && wrap_pulse);
   // R8
   a_r8_down_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !step_up && (count == CNT_ZERO)) |=> (count == $past(reload)) && wrap_pulse);
   // R9
   a_r9_pulse_needs_step: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> !wrap_pulse);
   // R10
   a_r10_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> $stable(count));
endmodule

// File: rtl/quad_enc_counter.sv
module quad_enc_counter #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cnt_en,
   input  logic [1:0]       mode,
   input  logic [CNT_W-1:0] reload,
   input  logic             ph_a,
   input  logic             ph_b,
   output logic [CNT_W-1:0] count,
   output logic             dir,
   output logic             wrap_pulse
);
   initial begin
      if (CNT_W < 2 || CNT_W > 32) $error("quad_enc_counter: CNT_W must lie in 2..32");
   end

   logic step;
   logic step_up;

   qenc_edge_detect i_edge (
      .clk     (clk),
      .rst_n   (rst_n),
      .cnt_en  (cnt_en),
      .mode    (mode),
      .ph_a    (ph_a),
      .ph_b    (ph_b),
      .step    (step),
      .step_up (step_up)
   );

   qenc_wrap_counter #(.CNT_W(CNT_W)) i_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .step       (step),
      .step_up    (step_up),
      .reload     (reload),
      .count      (count),
      .wrap_pulse (wrap_pulse)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    dir <= 1'b0;
      else if (step) dir <= ~step_up;
   end

   // R6
   a_r6_dir_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> $stable(dir));
   a_r6_dir_follows: assert property (@(posedge clk) disable iff (!rst_n)
      step |=> (dir == !$past(step_up)));
endmodule

// File: tb/test_quad_enc_counter.sv
`timescale 1ns/1ps
module test_quad_enc_counter;
   localparam int W = 8;
   localparam int MAXC = 200000;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cnt_en = 1'b0;
   logic [1:0]   mode = 2'd0;
   logic [W-1:0] reload = '0;
   logic         ph_a = 1'b0;
   logic         ph_b = 1'b0;
   logic [W-1:0] count;
   logic         dir;
   logic         wrap_pulse;

   int checks = 0;
   int fails = 0;
   int cycles = 0;

   // model state
   logic [W-1:0] m_cnt = '0;
   logic         m_dir = 1'b0;
   logic         m_wrap = 1'b0;
   logic         m_pa = 1'b0, m_pb = 1'b0, m_primed = 1'b0;
   string        m_tag = "R1";

   always #2 clk = ~clk;

   quad_enc_counter #(.CNT_W(W)) i_quad_enc_counter (
      .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .mode(mode), .reload(reload),
      .ph_a(ph_a), .ph_b(ph_b), .count(count), .dir(dir), .wrap_pulse(wrap_pulse)
   );

   function automatic logic up_of(input logic ea, input logic a, input logic b);
      if (ea) return a ^ b;   // R5 phase A rule
      return ~(a ^ b);        // R5 phase B rule
   endfunction

   // Advance the model by one clock edge (R12: result visible at that edge)
   task automatic model_edge();
      logic ea, eb, stp, up;
      ea = m_primed && (ph_a != m_pa);
      eb = m_primed && (ph_b != m_pb);
      m_wrap = 1'b0;
      m_tag = "R12";
      stp = 1'b0;
      if (ea && eb) m_tag = "R11";
      else if (!cnt_en || mode == 2'd0) begin
         if (ea || eb) m_tag = "R10";
      end else begin
         if (ea && mode[0]) stp = 1'b1;
         if (eb && mode[1]) stp = 1'b1;
         if (ea || eb) m_tag = (mode == 2'd1) ? "R2" : (mode == 2'd2) ? "R3" : "R4";
      end
      if (stp) begin
         up = up_of(ea, ph_a, ph_b);
         m_dir = ~up;
         if (up) begin
            if (m_cnt >= reload) begin m_cnt = '0; m_wrap = 1'b1; m_tag = "R7"; end
            else m_cnt = m_cnt + 1'b1;
         end else begin
            if (m_cnt == '0) begin m_cnt = reload; m_wrap = 1'b1; m_tag = "R8"; end
            else m_cnt = m_cnt - 1'b1;
         end
      end
      m_pa = ph_a; m_pb = ph_b; m_primed = 1'b1;
   endtask

   task automatic compare(input string tag);
      checks++;
      if (count !== m_cnt || dir !== m_dir || wrap_pulse !== m_wrap) begin
         fails++;
         $display("FAIL %s: count=%0d dir=%0b wrap=%0b expected count=%0d dir=%0b wrap=%0b",
                  tag, count, dir, wrap_pulse, m_cnt, m_dir, m_wrap);
      end
   endtask

   // Drive at negedge, let one posedge pass, check at the following negedge
   task automatic cyc(input logic a, input logic b, input logic [1:0] md, input logic en);
      ph_a = a; ph_b = b; mode = md; cnt_en = en;
      @(posedge clk);
      model_edge();
      @(negedge clk);
      cycles++;
      compare(m_tag);
      if (m_tag == "R7" || m_tag == "R8") compare("R9");
      if (m_tag == "R11" || m_tag == "R10") compare("R6");
   endtask

   task automatic fwd(input logic [1:0] md, input int n);
      for (int i = 0; i < n; i++) begin
         case ({ph_a, ph_b})
            2'b00: cyc(1, 0, md, 1);
            2'b10: cyc(1, 1, md, 1);
            2'b11: cyc(0, 1, md, 1);
            default: cyc(0, 0, md, 1);
         endcase
      end
   endtask

   task automatic rev(input logic [1:0] md, input int n);
      for (int i = 0; i < n; i++) begin
         case ({ph_a, ph_b})
            2'b00: cyc(0, 1, md, 1);
            2'b01: cyc(1, 1, md, 1);
            2'b11: cyc(1, 0, md, 1);
            default: cyc(0, 0, md, 1);
         endcase
      end
   endtask

   initial begin
      void'($urandom(32'd20240611));
      ph_a = 1'b1; ph_b = 1'b1;   // non-zero levels at release must not count (R1)
      repeat (3) @(negedge clk);
      checks++;
      if (count !== '0 || dir !== 1'b0 || wrap_pulse !== 1'b0) begin
         fails++;
         $display("FAIL R1: count=%0d dir=%0b wrap=%0b expected 0 0 0", count, dir, wrap_pulse);
      end
      reload = 8'd3;
      m_pa = 1'b0; m_pb = 1'b0;
      rst_n = 1'b1;
      cyc(1, 1, 2'd3, 1);            // R1: first sample after reset primes history only
      // directed: up through wrap (R7), down through wrap (R8)
      fwd(2'd3, 6);
      rev(2'd3, 7);
      // R2 / R3: single-phase modes
      fwd(2'd1, 8);
      rev(2'd2, 8);
      // R10: off mode and disabled
      fwd(2'd0, 4);
      for (int i = 0; i < 4; i++) cyc(~ph_a, ph_b, 2'd3, 0);
      // R11: both phases together
      cyc(~ph_a, ~ph_b, 2'd3, 1);
      cyc(~ph_a, ~ph_b, 2'd1, 1);
      // random walk
      reload = 8'd12;
      for (int i = 0; i < 4000; i++) begin
         int r;
         logic [1:0] md;
         md = mode;
         if ($urandom % 60 == 0) md = 2'($urandom % 4);
         if ($urandom % 400 == 0) reload = 8'($urandom % 20 + 1);
         r = $urandom % 10;
         if (r == 0)      cyc(~ph_a, ~ph_b, md, 1'b1);
         else if (r == 1) cyc(ph_a, ph_b, md, ($urandom % 8) != 0);
         else if (r[0])   cyc(~ph_a, ph_b, md, ($urandom % 10) != 0);
         else             cyc(ph_a, ~ph_b, md, ($urandom % 10) != 0);
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (MAXC) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog: cycles=%0d expected completion", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule